// File: doc/BRIEF.md
# I2C Slave Address Matcher with Masking

This block sits on an I2C bus as the address stage of a slave. It brings SCL and SDA into the system clock domain and finds START and STOP conditions. It then shifts in the address phase and compares it with a programmable own address. A 5-bit mask turns selected address bits into don't-cares, so one slave can answer a whole block of addresses. The mask maps onto the address bits in a different way in 7-bit mode than in 10-bit mode.

In 7-bit mode one address byte is checked. In 10-bit mode the slave first checks a header byte that carries the two upper address bits, and then checks the low address byte. When the whole address matches, the slave pulls SDA low for the acknowledge clock. It also stores the last address byte it received in a buffer, so the host can tell which of the masked addresses was used, and it pulses an interrupt. Any bytes that follow the address are not handled here.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `sda_oe` is 0, `match_irq` is 0 and `rx_buf` is 00h.
- R2: In 7-bit mode (`mode_10b`=0), bits 7..1 of the received byte are the address and bit 0 (R/W) is ignored. The byte is acknowledged when every address bit k (k = 1..7) equals `own_addr[k]`, or when k is 1..5 and `addr_mask[k-1]` is 1.
- R3: In 7-bit mode with `own_addr[7:0]`=A0h and `addr_mask`=00111b, the bytes A0h, A2h, A8h, AEh and A1h are acknowledged. B0h and 20h are not.
- R4: In 10-bit mode, `addr_mask[4:1]` masks low-address bits 5..2 and `addr_mask[0]` masks low-address bits 1 and 0 together. With a low own address of A0h and a mask of 00111b, every low byte from A0h to AFh is acknowledged and 9Fh and B0h are not.
- R5: In 10-bit mode, the first byte is acknowledged only if it equals {11110b, `own_addr[9:8]`, 0}. The mask never applies to this byte.
- R6: SDA is driven low only from the SCL fall after the 8th address bit to the SCL fall after the 9th clock. It is released at every other time.
- R7: When the final address byte matches, `rx_buf` takes that byte and `match_irq` pulses for one cycle. No interrupt is raised after the 10-bit header byte alone, and `rx_buf` changes only at such a pulse.
- R8: On a mismatch there is no ACK and no interrupt, `rx_buf` is unchanged, and the slave ignores the bus until the next START.
- R9: A STOP or a repeated START aborts an address phase in progress. A fresh START restarts bit counting from the first bit.
- R10: With all mask bits set, exactly 32 of the 128 possible 7-bit addresses are acknowledged, and exactly 64 of the 256 possible 10-bit low bytes are acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| mode_10b | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own address; 7-bit mode uses bits 7..1, 10-bit mode uses bits 9..0 |
| addr_mask | input | 5 | Mask bits for address bits 5..1; a 1 makes a bit a don't-care |
| rx_buf | output | 8 | Last matched final address byte |
| match_irq | output | 1 | One-cycle pulse on a full address match |

## Verification
The assertions assume that `mode_10b`, `own_addr` and `addr_mask` stay constant for the whole of a transaction. They also assume that SDA changes only while SCL is low, except for deliberate START and STOP conditions, and that each SCL level lasts several system clocks. The stimulus changes the configuration only between transactions, while the bus is idle. It changes SDA a few clocks after SCL has fallen and holds each SCL phase for six clocks, so the synchronised SCL and SDA keep the same order of events as the bus.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ACKW  = 2'd2,
    ST_ACK   = 2'd3
  } am_state_t;

  // care bits (1 = must match) over the 8-bit byte in 7-bit mode; bit 0 is R/W
  function automatic logic [7:0] care7(input logic [4:0] m);
    return ~{2'b00, m, 1'b1};
  endfunction

  // care bits over the 10-bit low byte: m[0] covers the two lowest bits
  function automatic logic [7:0] care10(input logic [4:0] m);
    return ~{2'b00, m[4:1], m[0], m[0]};
  endfunction

  function automatic logic hit7(input logic [7:0] b, input logic [7:0] own,
                                input logic [4:0] m);
    return ((b ^ own) & care7(m)) == 8'h00;
  endfunction

  function automatic logic hit10_hdr(input logic [7:0] b, input logic [1:0] hi);
    return b == {5'b11110, hi, 1'b0};
  endfunction

  function automatic logic hit10_lo(input logic [7:0] b, input logic [7:0] own,
                                    input logic [4:0] m);
    return ((b ^ own) & care10(m)) == 8'h00;
  endfunction

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
(
  input  logic [7:0] rx_byte,
  input  logic       second,
  input  logic       mode_10b,
  input  logic [9:0] own_addr,
  input  logic [4:0] addr_mask,
  output logic       hit,
  output logic       last
);
  always_comb begin
    if (!mode_10b) begin
      hit  = hit7(rx_byte, own_addr[7:0], addr_mask);
      last = 1'b1;
    end else if (!second) begin
      hit  = hit10_hdr(rx_byte, own_addr[9:8]);
      last = 1'b0;
    end else begin
      hit  = hit10_lo(rx_byte, own_addr[7:0], addr_mask);
      last = 1'b1;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       mode_10b,
  input  logic [9:0] own_addr,
  input  logic [4:0] addr_mask,
  output logic [7:0] rx_buf,
  output logic       match_irq
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] shreg, byte_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic              second, final_q;
  logic              cmp_hit, cmp_last;
  am_state_t         st;

  i2c_am_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2c_am_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_next = {shreg[BYTE_W-2:0], sda_s};

  i2c_am_cmp u_cmp (
    .rx_byte(byte_next), .second(second), .mode_10b(mode_10b),
    .own_addr(own_addr), .addr_mask(addr_mask),
    .hit(cmp_hit), .last(cmp_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      second    <= 1'b0;
      final_q   <= 1'b0;
      sda_oe    <= 1'b0;
      rx_buf    <= '0;
      match_irq <= 1'b0;
    end else begin
      match_irq <= 1'b0;
      if (start_det) begin
        st      <= ST_SHIFT;
        bit_cnt <= '0;
        second  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_SHIFT: if (scl_rise) begin
            shreg <= byte_next;
            if (bit_cnt == LAST_BIT) begin
              if (cmp_hit) begin
                st      <= ST_ACKW;
                final_q <= cmp_last;
                if (cmp_last) begin
                  rx_buf    <= byte_next;
                  match_irq <= 1'b1;
                end
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            if (final_q) begin
              st <= ST_IDLE;
            end else begin
              st      <= ST_SHIFT;
              bit_cnt <= '0;
              second  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       match_irq,
  input logic [7:0] rx_buf,
  input logic       mode_10b,
  input logic [9:0] own_addr,
  input logic [4:0] addr_mask
);
  // R6
  ack_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  // R7
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_irq |-> $stable(rx_buf));

  // R2
  seven_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && !mode_10b) |->
      (rx_buf[7:6] == own_addr[7:6]) &&
      ((rx_buf[5:1] ^ own_addr[5:1]) & ~addr_mask) == 5'd0);

  // R4
  ten_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && mode_10b) |->
      (rx_buf[7:6] == own_addr[7:6]) &&
      ((rx_buf[5:2] ^ own_addr[5:2]) & ~addr_mask[4:1]) == 4'd0 &&
      (addr_mask[0] || rx_buf[1:0] == own_addr[1:0]));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .match_irq(match_irq), .rx_buf(rx_buf),
  .mode_10b(mode_10b), .own_addr(own_addr), .addr_mask(addr_mask)
);

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, match_irq, mode_10b;
  logic [9:0] own_addr;
  logic [4:0] addr_mask;
  logic [7:0] rx_buf;
  logic sda_bus;
  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .mode_10b(mode_10b), .own_addr(own_addr), .addr_mask(addr_mask),
    .rx_buf(rx_buf), .match_irq(match_irq)
  );

  always @(posedge clk) if (rst_n && match_irq) irq_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-bit model: bit i must match unless a mask bit covers it
  function automatic bit exp7(input logic [7:0] b, input logic [7:0] own, input logic [4:0] m);
    for (int i = 1; i < 8; i++) begin
      bit dc = (i <= 5) ? m[i-1] : 1'b0;
      if (!dc && b[i] != own[i]) return 0;
    end
    return 1;
  endfunction

  function automatic bit exp10(input logic [7:0] b, input logic [7:0] own, input logic [4:0] m);
    for (int i = 0; i < 8; i++) begin
      bit dc = (i < 2) ? m[0] : (i <= 5) ? m[i-1] : 1'b0;
      if (!dc && b[i] != own[i]) return 0;
    end
    return 1;
  endfunction

  task automatic start_c();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic stop_c();
    scl_m = 1'b0; wt(2);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic v);
    wt(2); sda_m = v; wt(H-2);
    scl_m = 1'b1; wt(H/2);
    chk(sda_bus == v, "R6 released during data bit", sda_bus, v);
    wt(H/2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wt(2); sda_m = 1'b1; wt(H-2);
    scl_m = 1'b1; wt(H/2);
    ack = !sda_bus;
    wt(H/2); scl_m = 1'b0; wt(H);
    chk(sda_oe == 1'b0, "R6 released after ninth clock", sda_oe, 0);
  endtask

  task automatic cfg(input bit m10, input logic [9:0] own, input logic [4:0] m);
    mode_10b = m10; own_addr = own; addr_mask = m;
  endtask

  task automatic try7(input logic [7:0] b, input string req);
    bit ack, e; int i0; logic [7:0] buf0;
    e = exp7(b, own_addr[7:0], addr_mask);
    i0 = irq_cnt; buf0 = rx_buf;
    start_c(); send_byte(b, ack); stop_c();
    chk(ack == e, req, ack, e);
    chk(irq_cnt - i0 == int'(e), {req, " irq"}, irq_cnt - i0, e);
    chk(rx_buf == (e ? b : buf0), {req, " buffer"}, rx_buf, e ? b : buf0);
  endtask

  task automatic try10(input logic [7:0] lo, input string req);
    bit a1, a2, e; int i0; logic [7:0] buf0;
    e = exp10(lo, own_addr[7:0], addr_mask);
    i0 = irq_cnt; buf0 = rx_buf;
    start_c(); send_byte({5'b11110, own_addr[9:8], 1'b0}, a1);
    chk(a1 == 1'b1, "R5 header acked", a1, 1);
    chk(irq_cnt == i0, "R7 no irq after header", irq_cnt - i0, 0);
    send_byte(lo, a2); stop_c();
    chk(a2 == e, req, a2, e);
    chk(irq_cnt - i0 == int'(e), {req, " irq"}, irq_cnt - i0, e);
    chk(rx_buf == (e ? lo : buf0), {req, " buffer"}, rx_buf, e ? lo : buf0);
  endtask

  task automatic t_reset();
    wt(3);
    chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    chk(match_irq == 0, "R1 irq", match_irq, 0);
    chk(rx_buf == 8'h00, "R1 rx_buf", rx_buf, 0);
  endtask

  task automatic t_seven_example();
    cfg(1'b0, 10'h0A0, 5'b00111);
    try7(8'hA0, "R3 A0h");
    try7(8'hA2, "R3 A2h");
    try7(8'hB0, "R3 B0h");
    try7(8'hAE, "R3 AEh");
    try7(8'hA1, "R2 R/W ignored");
    try7(8'h20, "R2 bit7 unmasked");
    try7(8'hA8, "R3 A8h");
  endtask

  task automatic t_seven_sweep();
    int hits = 0;
    cfg(1'b0, 10'h054, 5'b11111);
    for (int a = 0; a < 128; a++) begin
      bit ack;
      start_c(); send_byte(8'(a << 1), ack); stop_c();
      if (ack) hits++;
      if (ack != exp7(8'(a << 1), 8'h54, 5'b11111)) chk(0, "R10 7-bit per address", ack, !ack);
    end
    chk(hits == 32, "R10 7-bit count", hits, 32);
  endtask

  task automatic t_ten_example();
    bit a; int i0;
    cfg(1'b1, 10'h2A0, 5'b00111);
    try10(8'hA0, "R4 A0h");
    try10(8'hA5, "R4 A5h");
    try10(8'hAF, "R4 AFh");
    try10(8'hB0, "R4 B0h");
    try10(8'h9F, "R4 9Fh");
    i0 = irq_cnt;
    start_c(); send_byte(8'hF2, a); stop_c();
    chk(a == 0, "R5 wrong high bits", a, 0);
    start_c(); send_byte(8'hF5, a); stop_c();
    chk(a == 0, "R5 header with R/W=1", a, 0);
    cfg(1'b1, 10'h2A0, 5'b11111);
    start_c(); send_byte(8'hF6, a); stop_c();
    chk(a == 0, "R5 high bits never masked", a, 0);
    chk(irq_cnt == i0, "R5 no irq on bad header", irq_cnt - i0, 0);
  endtask

  task automatic t_ten_sweep();
    int hits = 0;
    cfg(1'b1, 10'h1C6, 5'b11111);
    for (int l = 0; l < 256; l++) begin
      bit a1, a2;
      start_c(); send_byte(8'hF2, a1); send_byte(8'(l), a2); stop_c();
      if (a2) hits++;
      if (a2 != exp10(8'(l), 8'hC6, 5'b11111)) chk(0, "R10 10-bit per address", a2, !a2);
    end
    chk(hits == 64, "R10 10-bit count", hits, 64);
  endtask

  task automatic t_ignore();
    bit a; int i0; logic [7:0] buf0;
    cfg(1'b0, 10'h0A0, 5'b00000);
    i0 = irq_cnt; buf0 = rx_buf;
    start_c(); send_byte(8'hB0, a);
    chk(a == 0, "R8 mismatch no ack", a, 0);
    send_byte(8'hA0, a); stop_c();
    chk(a == 0, "R8 ignored until START", a, 0);
    chk(irq_cnt == i0, "R8 no irq", irq_cnt - i0, 0);
    chk(rx_buf == buf0, "R8 buffer kept", rx_buf, buf0);
  endtask

  task automatic t_abort();
    bit a; int i0;
    cfg(1'b0, 10'h0A0, 5'b00000);
    i0 = irq_cnt;
    start_c();
    for (int i = 7; i >= 4; i--) send_bit(1'(8'hA0 >> i));
    stop_c();
    scl_m = 1'b0;
    send_byte(8'h0A, a);
    chk(a == 0, "R9 STOP aborts", a, 0);
    chk(irq_cnt == i0, "R9 no irq after STOP", irq_cnt - i0, 0);
    stop_c();
    start_c();
    for (int i = 7; i >= 5; i--) send_bit(1'(8'hA0 >> i));
    start_c();
    send_byte(8'hA0, a); stop_c();
    chk(a == 1, "R9 repeated START restarts count", a, 1);
    chk(irq_cnt - i0 == 1, "R9 irq after restart", irq_cnt - i0, 1);
  endtask

  initial begin
    cfg(1'b0, 10'h0A0, 5'b00000);
    wt(4); rst_n = 1'b1;
    t_reset();
    t_seven_example();
    t_ignore();
    t_abort();
    t_ten_example();
    t_seven_sweep();
    t_ten_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule